// File: doc/BRIEF.md
# Banked Data Address Mapper

This block turns a 16-bit data address into a physical target and address. The lower half of the address space goes to internal data RAM without change. The top quarter is an I/O region, and only a sixteen-address slice of it may be used. The quarter between them is a 16 KiB sliding window. One mapping register decides where the window points: either a bank of instruction memory or a sub-bank of one segment of a segmented unified memory.

Target select and physical address are combinational in the address and the mapping register. A qualified access that falls on an illegal I/O address, or on a unified segment that the present vector marks as absent, raises a bus error. That error is registered and holds until the requester acknowledges it.

A two-state machine holds the error:
- ST_CLEAR is the idle state. It moves to ST_FAULT on a faulting access.
- ST_FAULT stays where it is until `err_ack` arrives in a cycle that has no new faulting access. It then returns to ST_CLEAR.

Top module: `dmap_xlate`

## Requirements
- R1: After reset the mapping register is zero and `bus_err` is low. As a result, address 0x8000 targets unified memory at physical address 0.
- R2: Addresses 0x0000 to 0x7FFF give target code 0 (data RAM), with a physical address equal to the input address.
- R3: Addresses 0xC000 to 0xFFFF give target code 1 (I/O), with a physical address equal to the input address. Only 0xFF00 to 0xFF0F are legal. A qualified access to any other address in this region faults.
- R4: In the window 0x8000 to 0xBFFF with mapping bit 12 set, the target code is 2 (instruction memory). The physical address is mapping bits 3:0 times 0x4000 plus input bits 13:0.
- R5: In the window with mapping bit 12 clear, the target code is 3 (unified memory). The segment is mapping bits 9:3 and the sub-bank is mapping bits 2:0. The physical address is segment times 0x20000, plus sub-bank times 0x4000, plus input bits 13:0.
- R6: A qualified access (`access_valid` high) to a unified segment whose bit in `seg_present` (indexed by segment number) is 0 drives `bus_err` high from the next cycle.
- R7: `bus_err` stays high until a cycle with `err_ack` high and no new faulting access. It is low from the cycle after that. A new fault in the same cycle as the acknowledge keeps it high.
- R8: A faulting address presented while `access_valid` is low does not set `bus_err`.
- R9: A mapping write takes effect from the cycle after it. Write bits 15:13 and 11:10 have no effect, and neither do bits 11:4 when the window targets instruction memory.
- R10: Accesses to data RAM and to the instruction-memory window never fault, whatever `seg_present` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_wr_en | input | 1 | Write strobe for the mapping register |
| map_wr_data | input | 16 | New mapping register value |
| seg_present | input | 128 | One bit per unified segment, 1 = present |
| addr_in | input | 16 | Data address to translate |
| access_valid | input | 1 | Qualifies `addr_in` as a real access for fault capture |
| err_ack | input | 1 | Acknowledges and clears a held bus error |
| target | output | 2 | 0 data RAM, 1 I/O, 2 instruction memory, 3 unified memory |
| phys_addr | output | 24 | Physical address in the selected target |
| bus_err | output | 1 | Registered, held bus error |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, a 14-bit window, 4 instruction-memory bank bits, 3 sub-bank bits and 7 segment bits. At that size every one of the 65,536 input addresses can be swept against an arithmetic model. So can all 16 instruction-memory banks and all 1,024 unified segment/sub-bank settings. The fault path uses a present vector that marks only even segments as present, so both outcomes appear on adjacent settings. The bench also walks the I/O region edges at 0xFEFF, 0xFF00, 0xFF0F and 0xFF10.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IO   = 2'd1,
        TGT_IMEM = 2'd2,
        TGT_UMEM = 2'd3
    } dmap_tgt_e;

    typedef enum logic [1:0] {
        RG_DRAM = 2'd0,
        RG_WIN  = 2'd1,
        RG_IO   = 2'd2
    } dmap_region_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_FAULT = 1'b1
    } dmap_err_st_e;
endpackage

// File: rtl/dmap_region.sv
module dmap_region
    import dmap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dmap_region_e      region,
    output logic              io_legal
);
    localparam int IO_TAG_W = ADDR_W - 4;

    always_comb begin
        if (!addr[ADDR_W-1])
            region = RG_DRAM;
        else if (!addr[ADDR_W-2])
            region = RG_WIN;
        else
            region = RG_IO;
    end

    // legal I/O slice: all ones above a zero nibble, then 16 words
    assign io_legal = (addr[ADDR_W-1:4] == {{(IO_TAG_W-4){1'b1}}, 4'b0000});
endmodule

// File: rtl/dmap_window.sv
module dmap_window #(
    parameter int WIN_W       = 14,
    parameter int IMEM_BANK_W = 4,
    parameter int SUB_BANK_W  = 3,
    parameter int SEG_W       = 7,
    parameter int FIELD_W     = SEG_W + SUB_BANK_W,
    parameter int PA_W        = FIELD_W + WIN_W
) (
    input  logic               sel_imem,
    input  logic [FIELD_W-1:0] field,
    input  logic [WIN_W-1:0]   offset,
    output logic [SEG_W-1:0]   seg_idx,
    output logic [PA_W-1:0]    win_phys
);
    localparam int IMEM_PA_W = IMEM_BANK_W + WIN_W;

    logic [IMEM_PA_W-1:0] imem_pa;
    logic [PA_W-1:0]      umem_pa;

    assign seg_idx = field[FIELD_W-1:SUB_BANK_W];
    assign imem_pa = {field[IMEM_BANK_W-1:0], offset};
    assign umem_pa = {seg_idx, field[SUB_BANK_W-1:0], offset};

    always_comb begin
        if (sel_imem)
            win_phys = PA_W'(imem_pa);
        else
            win_phys = umem_pa;
    end
endmodule

// File: rtl/dmap_err_fsm.sv
module dmap_err_fsm
    import dmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_req,
    input  logic err_ack,
    output logic bus_err
);
    dmap_err_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (fault_req) state_d = ST_FAULT;
            ST_FAULT: if (err_ack && !fault_req) state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        bus_err = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/dmap_xlate.sv
module dmap_xlate
    import dmap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int MAP_W       = 16,
    parameter int IMEM_BANK_W = 4,
    parameter int SUB_BANK_W  = 3,
    parameter int SEG_W       = 7,
    parameter int NUM_SEG     = 1 << SEG_W,
    parameter int PA_W        = SEG_W + SUB_BANK_W + ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_wr_en,
    input  logic [MAP_W-1:0]   map_wr_data,
    input  logic [NUM_SEG-1:0] seg_present,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               access_valid,
    input  logic               err_ack,
    output logic [1:0]         target,
    output logic [PA_W-1:0]    phys_addr,
    output logic               bus_err
);
    localparam int WIN_W   = ADDR_W - 2;
    localparam int FIELD_W = SEG_W + SUB_BANK_W;
    localparam int SEL_BIT = 12;

    logic               sel_q;
    logic [FIELD_W-1:0] field_q;
    logic               unused_map_bits;

    dmap_region_e       region;
    logic               io_legal;
    logic [SEG_W-1:0]   seg_idx;
    logic [PA_W-1:0]    win_phys;
    dmap_tgt_e          tgt;
    logic               fault_cond;
    logic               fault_req;

    assign unused_map_bits = ^{map_wr_data[MAP_W-1:SEL_BIT+1],
                               map_wr_data[SEL_BIT-1:FIELD_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            field_q <= '0;
        end else if (map_wr_en) begin
            sel_q   <= map_wr_data[SEL_BIT];
            field_q <= map_wr_data[FIELD_W-1:0];
        end
    end

    dmap_region #(.ADDR_W(ADDR_W)) u_region (
        .addr     (addr_in),
        .region   (region),
        .io_legal (io_legal)
    );

    dmap_window #(
        .WIN_W       (WIN_W),
        .IMEM_BANK_W (IMEM_BANK_W),
        .SUB_BANK_W  (SUB_BANK_W),
        .SEG_W       (SEG_W),
        .FIELD_W     (FIELD_W),
        .PA_W        (PA_W)
    ) u_window (
        .sel_imem (sel_q),
        .field    (field_q),
        .offset   (addr_in[WIN_W-1:0]),
        .seg_idx  (seg_idx),
        .win_phys (win_phys)
    );

    always_comb begin
        tgt        = TGT_DRAM;
        phys_addr  = PA_W'(addr_in);
        fault_cond = 1'b0;
        unique case (region)
            RG_DRAM: begin
                tgt = TGT_DRAM;
            end
            RG_IO: begin
                tgt        = TGT_IO;
                fault_cond = !io_legal;
            end
            RG_WIN: begin
                tgt        = sel_q ? TGT_IMEM : TGT_UMEM;
                phys_addr  = win_phys;
                fault_cond = !sel_q && !seg_present[seg_idx];
            end
            default: begin
                tgt = TGT_DRAM;
            end
        endcase
    end

    assign target    = tgt;
    assign fault_req = access_valid && fault_cond;

    dmap_err_fsm u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_req (fault_req),
        .err_ack   (err_ack),
        .bus_err   (bus_err)
    );
endmodule

// File: rtl/dmap_xlate_chk.sv
module dmap_xlate_chk
    import dmap_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SEG_W   = 7,
    parameter int NUM_SEG = 1 << SEG_W,
    parameter int PA_W    = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SEG-1:0] seg_present,
    input logic [ADDR_W-1:0]  addr_in,
    input logic               access_valid,
    input logic               err_ack,
    input logic [1:0]         target,
    input logic [PA_W-1:0]    phys_addr,
    input logic               bus_err
);
    localparam int IMEM_TOP = ADDR_W + 2;

    p_dram_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_in[ADDR_W-1] |-> (target == TGT_DRAM && phys_addr == PA_W'(addr_in)));

    p_io_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (access_valid && target == TGT_IO &&
         addr_in[ADDR_W-1:4] != {{(ADDR_W-8){1'b1}}, 4'b0000}) |=> bus_err);

    p_imem_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (target == TGT_IMEM) |-> (phys_addr[PA_W-1:IMEM_TOP] == '0));

    p_umem_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (access_valid && target == TGT_UMEM &&
         !seg_present[phys_addr[PA_W-1:PA_W-SEG_W]]) |=> bus_err);

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_ack) |=> bus_err);

    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && err_ack && !access_valid) |=> !bus_err);

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_err && !access_valid) |=> !bus_err);

    p_safe_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_err && access_valid &&
         (target == TGT_IMEM || target == TGT_DRAM)) |=> !bus_err);
endmodule

bind dmap_xlate dmap_xlate_chk #(
    .ADDR_W  (ADDR_W),
    .SEG_W   (SEG_W),
    .NUM_SEG (NUM_SEG),
    .PA_W    (PA_W)
) u_chk (.*);

// File: tb/dmap_xlate_tb.sv
`timescale 1ns/1ps
module dmap_xlate_tb;
    localparam int NUM_SEG = 128;
    localparam int PA_W    = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               map_wr_en = 1'b0;
    logic [15:0]        map_wr_data = '0;
    logic [NUM_SEG-1:0] seg_present = '1;
    logic [15:0]        addr_in = '0;
    logic               access_valid = 1'b0;
    logic               err_ack = 1'b0;
    logic [1:0]         target;
    logic [PA_W-1:0]    phys_addr;
    logic               bus_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] cur_map = '0;

    always #10 clk = ~clk;

    dmap_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
        .seg_present(seg_present), .addr_in(addr_in), .access_valid(access_valid),
        .err_ack(err_ack), .target(target), .phys_addr(phys_addr), .bus_err(bus_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run exceeded cycle budget, actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected {target, phys} from the requirement arithmetic
    function automatic logic [31:0] model(input logic [15:0] m, input logic [15:0] a);
        logic [31:0] pa;
        logic [1:0]  t;
        if (a < 16'h8000) begin t = 2'd0; pa = 32'(a); end
        else if (a >= 16'hC000) begin t = 2'd1; pa = 32'(a); end
        else if (m[12]) begin t = 2'd2; pa = 32'(m[3:0]) * 32'h4000 + 32'(a & 16'h3FFF); end
        else begin
            t  = 2'd3;
            pa = 32'(m[9:3]) * 32'h20000 + 32'(m[2:0]) * 32'h4000 + 32'(a & 16'h3FFF);
        end
        return {6'd0, t, pa[23:0]};
    endfunction

    task automatic write_map(input logic [15:0] v);
        @(negedge clk);
        map_wr_en   = 1'b1;
        map_wr_data = v;
        @(negedge clk);
        map_wr_en = 1'b0;
        cur_map   = v;
    endtask

    task automatic probe(input string req, input logic [15:0] a);
        addr_in = a;
        #1;
        chk(req, {6'd0, target, phys_addr}, model(cur_map, a));
    endtask

    // one qualified access, then bus_err sampled after the capturing edge
    task automatic access(input logic [15:0] a, input logic valid);
        @(negedge clk);
        addr_in      = a;
        access_valid = valid;
        @(negedge clk);
        access_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        #1;
        chk("R1 bus_err after reset", {31'd0, bus_err}, 32'd0);
        probe("R1 window at reset", 16'h8000);
        rst_n = 1'b1;
        @(negedge clk);
        probe("R1 window after reset release", 16'h8000);

        // R2/R3/R5 exhaustive sweep with map 0
        for (int a = 0; a < 65536; a++) begin
            if (a < 32768)       probe("R2 data RAM sweep", 16'(a));
            else if (a >= 49152) probe("R3 I/O sweep", 16'(a));
            else                 probe("R5 window sweep map0", 16'(a));
        end

        // R4/R9 every instruction bank, junk in ignored bits
        for (int b = 0; b < 16; b++) begin
            write_map(16'h1000 | 16'(b) | (16'(b * 37) << 4 & 16'h0FF0) | 16'hE000);
            probe("R4 imem bank low", 16'h8000);
            probe("R4 imem bank mid", 16'h9A5C);
            probe("R4 imem bank high", 16'hBFFF);
            probe("R9 data RAM unaffected", 16'h1234);
        end

        // R5/R9 every segment and sub-bank
        for (int v = 0; v < 1024; v++) begin
            write_map(16'(v) | 16'hEC00);
            probe("R5 umem low", 16'h8000);
            probe("R5 umem high", 16'hBFFF);
        end

        // R9 write takes effect the cycle after
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_data = 16'h1005; addr_in = 16'h8010;
        #1;
        chk("R9 old map before edge", {6'd0, target, phys_addr}, model(cur_map, 16'h8010));
        @(negedge clk);
        map_wr_en = 1'b0; cur_map = 16'h1005;
        probe("R9 new map after edge", 16'h8010);

        // R6 fault on absent segment: only even segments present
        for (int s = 0; s < NUM_SEG; s++) seg_present[s] = (s % 2 == 0);
        for (int s = 0; s < 8; s++) begin
            write_map(16'(s << 3) | 16'h0002);
            access(16'hA000, 1'b1);
            #1;
            chk("R6 segment fault", {31'd0, bus_err}, (s % 2 == 1) ? 32'd1 : 32'd0);
            ack();
            #1;
            chk("R7 ack clears", {31'd0, bus_err}, 32'd0);
        end

        // R8 faulting address without valid
        write_map(16'h0008);
        access(16'hA000, 1'b0);
        #1;
        chk("R8 unqualified umem", {31'd0, bus_err}, 32'd0);
        access(16'hC000, 1'b0);
        #1;
        chk("R8 unqualified io", {31'd0, bus_err}, 32'd0);

        // R3 I/O legality edges
        access(16'hFF00, 1'b1); #1; chk("R3 io FF00 legal", {31'd0, bus_err}, 32'd0);
        access(16'hFF0F, 1'b1); #1; chk("R3 io FF0F legal", {31'd0, bus_err}, 32'd0);
        access(16'hFEFF, 1'b1); #1; chk("R3 io FEFF faults", {31'd0, bus_err}, 32'd1);
        ack();
        access(16'hFF10, 1'b1); #1; chk("R3 io FF10 faults", {31'd0, bus_err}, 32'd1);
        ack();
        access(16'hC000, 1'b1); #1; chk("R3 io C000 faults", {31'd0, bus_err}, 32'd1);

        // R7 hold without ack, and set wins over ack
        repeat (3) @(negedge clk);
        #1;
        chk("R7 held", {31'd0, bus_err}, 32'd1);
        @(negedge clk);
        err_ack = 1'b1; access_valid = 1'b1; addr_in = 16'hFFFF;
        @(negedge clk);
        err_ack = 1'b0; access_valid = 1'b0;
        #1;
        chk("R7 new fault beats ack", {31'd0, bus_err}, 32'd1);
        ack();
        #1;
        chk("R7 cleared", {31'd0, bus_err}, 32'd0);

        // R10 no fault in data RAM or instruction window with no segments
        seg_present = '0;
        write_map(16'h100F);
        access(16'h8000, 1'b1); #1; chk("R10 imem never faults", {31'd0, bus_err}, 32'd0);
        access(16'h0000, 1'b1); #1; chk("R10 data RAM never faults", {31'd0, bus_err}, 32'd0);
        write_map(16'h0000);
        access(16'h8000, 1'b1); #1; chk("R6 segment 0 absent", {31'd0, bus_err}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule